// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is a register-mapped master for a single-wire serial bus. The bus is open-drain: the block pulls it low through `line_drive_low` and reads it back through `line_in`. The line can run in two modes. In slave-paced mode (mode bit 0), the slave starts every receive bit itself. In master-paced mode (mode bit 1), the master opens each read slot with a short low pulse. Software sets up an operation through a control register and starts it by writing the GO bit. GO then stays set until the operation is done, and nothing else can be started while it is set.

An operation is one of three kinds. It can be a reset pulse that checks for a presence reply, a transmit of a byte or one bit, or a receive of a byte or one bit. At the end, one completion cause is latched in an interrupt status register, which clears when read. The interrupt output is driven from the latched causes. All bit-slot timings are counts of clock cycles set by parameters, and bytes move least significant bit first.

Top module: `swire_master`

## Requirements
- R1: After reset, a read at byte offset 0x00 returns {REV_MAJOR, REV_MINOR} (0x13 with the default parameters), one nibble each. Reads at control (0x0C) and interrupt status (0x10) return 0x00. The line is released and `irq` is low. Register reads return data on the cycle after the read strobe.
- R2: Write the control register with GO (bit 4) = 1, DIR (bit 1) = 0 and CLKEN (bit 5) = 1, and the block sends the byte held at offset 0x04, LSB first. Each bit takes BIT_SLOT cycles. A 0 is a low of W0_LOW cycles and a 1 is a low of W1_LOW cycles. At the end, TX-done (interrupt status bit 2) is set and GO clears.
- R3: In master-paced mode (control bit 0 = 1), a GO with DIR = 1 runs read slots. Each slot has a low of RD_LOW cycles, then the line is released and sampled. The byte is assembled LSB first into the receive register at offset 0x08, and RX-done (bit 1) is set.
- R4: In slave-paced mode (bit 0 = 0), a receive waits for the slave to pull the line low. A short low reads as 1 and a long low reads as 0. If no falling edge comes within RESP_WIN cycles, the receive ends with TIMEOUT (bit 0) instead of RX-done, and the receive register keeps its old value.
- R5: INIT (bit 2) together with GO sends a reset pulse of RST_LOW cycles and then samples the line during recovery. The pulse ends with TIMEOUT set. PRESENCE (bit 3) is set if the line was low at the sample point and cleared otherwise. INIT and GO both clear.
- R6: With SINGLE (bit 7) set, only one bit moves. A transmit takes bit 0 of the transmit register. A receive puts the bit in bit 0 of the receive register and zeroes the upper bits.
- R7: A read of interrupt status returns the latched bits and clears them. A completion that arrives in the same cycle as the clearing read stays latched.
- R8: `irq` is the registered OR of the latched status bits, gated by the interrupt-enable bit (bit 6). With the enable low, `irq` stays low.
- R9: A GO written with CLKEN = 0 is ignored. GO reads back as 0, the line stays released and no status bit is set.
- R10: While GO is set, a control write changes only the interrupt-enable bit. A second GO or a change of DIR has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (interrupt status read clears) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |
| line_drive_low | output | 1 | Pull the bus line low when high |
| line_in | input | 1 | Sampled level of the bus line |

## Verification
Two functions can land in the same cycle: the clearing read of interrupt status and the sequencer's completion event that sets a bit in it. The bench provokes this by holding the read strobe high for every cycle across a whole transmit, so one of those reads must coincide with the completion. It counts how many read results carry TX-done, and exactly one must. If the clear wins, the count is zero. If the clear is lost, the bit shows up on more than one read, or again on a final read taken afterwards.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int BYTE_W = 8;

  // register byte offsets
  localparam logic [7:0] OFS_REV  = 8'h00;
  localparam logic [7:0] OFS_TX   = 8'h04;
  localparam logic [7:0] OFS_RX   = 8'h08;
  localparam logic [7:0] OFS_CTRL = 8'h0C;
  localparam logic [7:0] OFS_INT  = 8'h10;

  // control register bit positions
  localparam int CB_SINGLE = 7;
  localparam int CB_IEN    = 6;
  localparam int CB_CLKEN  = 5;
  localparam int CB_GO     = 4;
  localparam int CB_PRES   = 3;
  localparam int CB_INIT   = 2;
  localparam int CB_DIR    = 1;
  localparam int CB_MODE   = 0;

  // interrupt status bit positions
  localparam int IB_TX = 2;
  localparam int IB_RX = 1;
  localparam int IB_TO = 0;
  localparam int IRQ_W = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BRK_LOW,
    S_BRK_REC,
    S_WR,
    S_RD,
    S_HQ_WAIT,
    S_HQ_LOW,
    S_HQ_HIGH
  } seq_st_e;
endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/swm_seq.sv
module swm_seq
  import swm_pkg::*;
#(
  parameter int RST_LOW  = 48,
  parameter int RST_REC  = 40,
  parameter int PRES_AT  = 16,
  parameter int SLOT     = 24,
  parameter int W0_LOW   = 16,
  parameter int W1_LOW   = 4,
  parameter int RD_LOW   = 2,
  parameter int RD_AT    = 8,
  parameter int RESP_WIN = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_init,
  input  logic              op_dir,
  input  logic              op_single,
  input  logic              op_mode,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              line_s,
  output logic              drive_low,
  output logic [IRQ_W-1:0]  evt,
  output logic              pres,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(RST_LOW + RST_REC + SLOT + RESP_WIN + RD_AT + 1);
  localparam int BI_W  = $clog2(BYTE_W);

  seq_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [BI_W-1:0]   bidx;
  logic [BYTE_W-1:0] sh;
  logic [BI_W-1:0]   last_idx;
  logic [BYTE_W-1:0] rx_asm;

  assign last_idx = op_single ? '0 : BI_W'(BYTE_W - 1);
  assign rx_asm   = op_single ? {{(BYTE_W-1){1'b0}}, sh[BYTE_W-1]} : sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      sh        <= '0;
      drive_low <= 1'b0;
      evt       <= '0;
      pres      <= 1'b0;
      rx_byte   <= '0;
    end else begin
      evt <= '0;
      case (st)
        S_IDLE: begin
          if (start) begin
            cnt  <= '0;
            bidx <= '0;
            sh   <= op_dir ? '0 : tx_byte;
            if (op_init) begin
              pres      <= 1'b0;
              drive_low <= 1'b1;
              st        <= S_BRK_LOW;
            end else if (!op_dir) begin
              drive_low <= 1'b1;
              st        <= S_WR;
            end else if (op_mode) begin
              drive_low <= 1'b1;
              st        <= S_RD;
            end else begin
              st <= S_HQ_WAIT;
            end
          end
        end
        S_BRK_LOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(RST_LOW - 1)) begin
            drive_low <= 1'b0;
            cnt       <= '0;
            st        <= S_BRK_REC;
          end
        end
        S_BRK_REC: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(PRES_AT - 1)) pres <= !line_s;
          if (cnt == CNT_W'(RST_REC - 1)) begin
            evt[IB_TO] <= 1'b1;
            st         <= S_IDLE;
          end
        end
        S_WR: begin
          cnt <= cnt + 1'b1;
          if (sh[0] && cnt == CNT_W'(W1_LOW - 1))  drive_low <= 1'b0;
          if (!sh[0] && cnt == CNT_W'(W0_LOW - 1)) drive_low <= 1'b0;
          if (cnt == CNT_W'(SLOT - 1)) begin
            cnt <= '0;
            sh  <= sh >> 1;
            if (bidx == last_idx) begin
              evt[IB_TX] <= 1'b1;
              st         <= S_IDLE;
            end else begin
              bidx      <= bidx + 1'b1;
              drive_low <= 1'b1;
            end
          end
        end
        S_RD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(RD_LOW - 1)) drive_low <= 1'b0;
          if (cnt == CNT_W'(RD_AT - 1))  sh <= {line_s, sh[BYTE_W-1:1]};
          if (cnt == CNT_W'(SLOT - 1)) begin
            cnt <= '0;
            if (bidx == last_idx) begin
              evt[IB_RX] <= 1'b1;
              rx_byte    <= rx_asm;
              st         <= S_IDLE;
            end else begin
              bidx      <= bidx + 1'b1;
              drive_low <= 1'b1;
            end
          end
        end
        S_HQ_WAIT: begin
          cnt <= cnt + 1'b1;
          if (!line_s) begin
            cnt <= '0;
            st  <= S_HQ_LOW;
          end else if (cnt == CNT_W'(RESP_WIN - 1)) begin
            evt[IB_TO] <= 1'b1;
            st         <= S_IDLE;
          end
        end
        S_HQ_LOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(RD_AT - 1)) begin
            sh  <= {line_s, sh[BYTE_W-1:1]};
            cnt <= '0;
            st  <= S_HQ_HIGH;
          end
        end
        S_HQ_HIGH: begin
          cnt <= cnt + 1'b1;
          if (line_s) begin
            cnt <= '0;
            if (bidx == last_idx) begin
              evt[IB_RX] <= 1'b1;
              rx_byte    <= rx_asm;
              st         <= S_IDLE;
            end else begin
              bidx <= bidx + 1'b1;
              st   <= S_HQ_WAIT;
            end
          end else if (cnt == CNT_W'(RESP_WIN - 1)) begin
            evt[IB_TO] <= 1'b1;
            st         <= S_IDLE;
          end
        end
        default: begin
          st        <= S_IDLE;
          drive_low <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/swm_regs.sv
module swm_regs
  import swm_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int REV_MAJOR = 1,
  parameter int REV_MINOR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq,
  input  logic [IRQ_W-1:0]  evt,
  input  logic              pres_in,
  input  logic [BYTE_W-1:0] rx_in,
  output logic              start,
  output logic              go,
  output logic              clken,
  output logic              ien,
  output logic              single,
  output logic              dir,
  output logic              init,
  output logic              mode,
  output logic [BYTE_W-1:0] tx_q,
  output logic [IRQ_W-1:0]  flags
);
  logic              presence;
  logic [BYTE_W-1:0] rx_q;
  logic              sel_tx, sel_ctrl, sel_int;
  logic              go_req;
  logic              unused_pres_wr;

  assign sel_tx         = (addr == ADDR_W'(OFS_TX));
  assign sel_ctrl       = (addr == ADDR_W'(OFS_CTRL));
  assign sel_int        = (addr == ADDR_W'(OFS_INT));
  assign go_req         = wdata[CB_GO] & wdata[CB_CLKEN];
  assign unused_pres_wr = wdata[CB_PRES];

  always_ff @(posedge clk) begin
    if (rst) begin
      go       <= 1'b0;
      clken    <= 1'b0;
      ien      <= 1'b0;
      single   <= 1'b0;
      dir      <= 1'b0;
      init     <= 1'b0;
      mode     <= 1'b0;
      presence <= 1'b0;
      start    <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
      flags    <= '0;
      irq      <= 1'b0;
      rdata    <= '0;
    end else begin
      start <= 1'b0;
      if (|evt) begin
        go   <= 1'b0;
        init <= 1'b0;
      end
      if (evt[IB_TO] && init) presence <= pres_in;
      if (evt[IB_RX])         rx_q     <= rx_in;
      if (wr && sel_tx)       tx_q     <= wdata;
      if (wr && sel_ctrl) begin
        ien <= wdata[CB_IEN];
        if (!go) begin
          single <= wdata[CB_SINGLE];
          clken  <= wdata[CB_CLKEN];
          dir    <= wdata[CB_DIR];
          init   <= wdata[CB_INIT];
          mode   <= wdata[CB_MODE];
          go     <= go_req;
          start  <= go_req;
          if (go_req && wdata[CB_INIT]) presence <= 1'b0;
        end
      end
      flags <= ((rd && sel_int) ? '0 : flags) | evt;
      irq   <= ien & (|flags);
      if (rd) begin
        case (addr)
          ADDR_W'(OFS_REV):  rdata <= {4'(REV_MAJOR), 4'(REV_MINOR)};
          ADDR_W'(OFS_TX):   rdata <= tx_q;
          ADDR_W'(OFS_RX):   rdata <= rx_q;
          ADDR_W'(OFS_CTRL): rdata <= {single, ien, clken, go, presence, init, dir, mode};
          ADDR_W'(OFS_INT):  rdata <= {{(BYTE_W-IRQ_W){1'b0}}, flags};
          default:           rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/swire_master.sv
module swire_master
  import swm_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int REV_MAJOR = 1,
  parameter int REV_MINOR = 3,
  parameter int SYNC_N    = 2,
  parameter int RST_LOW   = 48,
  parameter int RST_REC   = 40,
  parameter int PRES_AT   = 16,
  parameter int SLOT      = 24,
  parameter int W0_LOW    = 16,
  parameter int W1_LOW    = 4,
  parameter int RD_LOW    = 2,
  parameter int RD_AT     = 8,
  parameter int RESP_WIN  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              line_drive_low,
  input  logic              line_in
);
  logic              st_start, st_go, st_clken, st_ien, st_single;
  logic              st_dir, st_init, st_mode;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic [IRQ_W-1:0]  ev_bus, fl_bus;
  logic              pres, line_s;

  swm_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(line_s)
  );

  swm_regs #(
    .ADDR_W(ADDR_W), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata), .irq(irq),
    .evt(ev_bus), .pres_in(pres), .rx_in(rx_byte),
    .start(st_start), .go(st_go), .clken(st_clken), .ien(st_ien),
    .single(st_single), .dir(st_dir), .init(st_init), .mode(st_mode),
    .tx_q(tx_byte), .flags(fl_bus)
  );

  swm_seq #(
    .RST_LOW(RST_LOW), .RST_REC(RST_REC), .PRES_AT(PRES_AT), .SLOT(SLOT),
    .W0_LOW(W0_LOW), .W1_LOW(W1_LOW), .RD_LOW(RD_LOW), .RD_AT(RD_AT),
    .RESP_WIN(RESP_WIN)
  ) u_seq (
    .clk(clk), .rst(rst), .start(st_start), .op_init(st_init),
    .op_dir(st_dir), .op_single(st_single), .op_mode(st_mode),
    .tx_byte(tx_byte), .line_s(line_s), .drive_low(line_drive_low),
    .evt(ev_bus), .pres(pres), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/swm_checker.sv
module swm_checker
  import swm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              irq,
  input logic              drive_low,
  input logic              go,
  input logic              clken,
  input logic              ien,
  input logic              single,
  input logic              dir,
  input logic              mode,
  input logic              init,
  input logic [IRQ_W-1:0]  evt,
  input logic [IRQ_W-1:0]  flags
);
  a_r9_line_needs_clken: assert property (@(posedge clk) disable iff (rst)
    drive_low |-> (go && clken));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq);

  a_r2_go_self_clears: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> !go);

  a_r5_single_cause: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evt));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(OFS_INT) && evt == '0) |=> (flags == '0));

  a_r10_frozen_while_busy: assert property (@(posedge clk) disable iff (rst)
    (go && $past(go)) |-> $stable({single, dir, mode, init, clken}));
endmodule

bind swire_master swm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .irq(irq),
  .drive_low(line_drive_low), .go(st_go), .clken(st_clken), .ien(st_ien),
  .single(st_single), .dir(st_dir), .mode(st_mode), .init(st_init),
  .evt(ev_bus), .flags(fl_bus)
);

// File: tb/sim_swire_master.sv
module sim_swire_master;
  localparam int CLK_PERIOD = 10;
  localparam int RST_LOW = 48;

  localparam logic [4:0] A_REV = 5'h00, A_TX = 5'h04, A_RX = 5'h08,
                         A_CTRL = 5'h0C, A_INT = 5'h10;

  // vector: mode, dir, single, data, expected
  localparam int NV = 7;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {1'b1, 1'b0, 1'b1, 8'h03, 8'h01},
    {1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C},
    {1'b1, 1'b1, 1'b0, 8'h96, 8'h96},
    {1'b0, 1'b1, 1'b0, 8'h5A, 8'h5A},
    {1'b1, 1'b1, 1'b1, 8'hFE, 8'h00},
    {1'b0, 1'b1, 1'b1, 8'h01, 8'h01}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, line_drive_low, line_in;

  logic s1_pull = 1'b0, hq_pull = 1'b0, pr_pull = 1'b0;
  assign line_in = !(line_drive_low | s1_pull | hq_pull | pr_pull);

  swire_master u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .line_drive_low(line_drive_low), .line_in(line_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // line monitor: decodes low pulses (short = 1)
  int lowc = 0, mon_n = 0, mon_first = 0;
  logic [7:0] mon_byte = '0;
  always @(negedge clk) begin
    if (!line_in) lowc++;
    else if (lowc != 0) begin
      if (mon_n == 0) mon_first = lowc;
      mon_byte = {(lowc < 10), mon_byte[7:1]};
      mon_n++;
      lowc = 0;
    end
  end
  task automatic mon_clear();
    @(negedge clk);
    mon_n = 0; mon_byte = '0; mon_first = 0;
  endtask

  // master-paced slave responder
  logic       s1_en = 1'b0, dl_prev = 1'b0;
  logic [7:0] s1_byte = '0;
  logic [2:0] s1_idx = '0;
  int         s1_hold = 0;
  always @(negedge clk) begin
    if (s1_hold > 0) begin
      s1_hold--;
      if (s1_hold == 0) s1_pull = 1'b0;
    end
    if (s1_en && line_drive_low && !dl_prev) begin
      s1_pull = !s1_byte[s1_idx];
      s1_hold = 14;
      s1_idx++;
    end
    dl_prev = line_drive_low;
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic hq_send(input logic [7:0] b, input int nb);
    for (int i = 0; i < nb; i++) begin
      repeat (10) @(negedge clk);
      hq_pull = 1'b1;
      repeat (b[i] ? 3 : 14) @(negedge clk);
      hq_pull = 1'b0;
    end
  endtask

  task automatic presence_reply();
    int g = 0;
    while (!line_drive_low && g < 200) begin @(negedge clk); g++; end
    while (line_drive_low && g < 400) begin @(negedge clk); g++; end
    repeat (5) @(negedge clk);
    pr_pull = 1'b1;
    repeat (20) @(negedge clk);
    pr_pull = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int g = 0;
    while (!irq && g < 3000) begin @(negedge clk); g++; end
    check({req, " irq raised"}, int'(irq), 1);
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int g = 0; g < 1000; g++) begin
      rd(A_CTRL, c);
      if (!c[4]) break;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, dec;
    logic [18:0] v;
    logic vm, vd, vs;
    int seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 line released", int'(line_drive_low), 0);
    check("R1 irq low", int'(irq), 0);
    rd(A_REV, d);  check("R1 revision", d, 8'h13);
    rd(A_CTRL, d); check("R1 ctrl reset", d, 8'h00);
    rd(A_INT, d);  check("R1 int reset", d, 8'h00);

    // table walk: R2 R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      vm = v[18]; vd = v[17]; vs = v[16];
      mon_clear();
      s1_idx = '0;
      wr(A_CTRL, {1'b0, 2'b11, 4'b0000, vm});
      if (!vd) wr(A_TX, v[15:8]);
      if (vd && vm) begin s1_byte = v[15:8]; s1_en = 1'b1; end
      if (vd && !vm) begin
        fork
          wr(A_CTRL, {vs, 3'b111, 2'b00, vd, vm});
          hq_send(v[15:8], vs ? 1 : 8);
        join
      end else begin
        wr(A_CTRL, {vs, 3'b111, 2'b00, vd, vm});
      end
      wait_irq("R2/R3/R4 vector");
      rd(A_INT, d);
      check(vd ? "R3/R4 rx-done flag" : "R2 tx-done flag", d, vd ? 8'h02 : 8'h04);
      if (vd) begin
        rd(A_RX, d);
        check(vs ? "R6 single rx data" : "R3/R4 rx data", d, v[7:0]);
      end else begin
        dec = vs ? {7'b0, mon_byte[7]} : mon_byte;
        check(vs ? "R6 single tx bit count" : "R2 tx bit count", mon_n, vs ? 1 : 8);
        check(vs ? "R6 single tx bit" : "R2 tx byte on line", dec, v[7:0]);
      end
      rd(A_CTRL, d);
      check("R2 GO cleared", d, {vs, 3'b110, 2'b00, vd, vm});
      s1_en = 1'b0;
    end

    // R4 timeout in slave-paced mode, rx register unchanged
    wr(A_CTRL, 8'h60);
    wr(A_CTRL, 8'h72);
    wait_irq("R4 timeout");
    rd(A_INT, d);  check("R4 timeout flag", d, 8'h01);
    rd(A_RX, d);   check("R4 rx kept", d, 8'h01);
    rd(A_CTRL, d); check("R4 GO cleared", d, 8'h62);

    // R5 reset pulse with presence
    mon_clear();
    wr(A_CTRL, 8'h61);
    fork
      wr(A_CTRL, 8'h75);
      presence_reply();
    join
    wait_irq("R5 break");
    rd(A_INT, d);  check("R5 break ends in timeout", d, 8'h01);
    rd(A_CTRL, d); check("R5 presence set, INIT/GO clear", d, 8'h69);
    check("R5 reset low width", mon_first, RST_LOW);

    // R5 reset pulse without presence
    wr(A_CTRL, 8'h75);
    wait_irq("R5 break no slave");
    rd(A_INT, d);  check("R5 no-slave flag", d, 8'h01);
    rd(A_CTRL, d); check("R5 presence cleared", d, 8'h61);

    // R9 GO with clock enable off
    mon_clear();
    wr(A_CTRL, 8'h51);
    repeat (300) @(negedge clk);
    check("R9 line untouched", mon_n + lowc, 0);
    rd(A_CTRL, d); check("R9 GO not taken", d, 8'h41);
    rd(A_INT, d);  check("R9 no flags", d, 8'h00);

    // R10 busy writes, R8 masked irq
    mon_clear();
    wr(A_CTRL, 8'h61);
    wr(A_TX, 8'hFF);
    wr(A_CTRL, 8'h71);
    wr(A_CTRL, 8'h33);
    rd(A_CTRL, d); check("R10 only enable changed", d, 8'h31);
    wait_idle();
    check("R10 tx bit count", mon_n, 8);
    check("R10 tx byte kept", mon_byte, 8'hFF);
    check("R8 irq masked", int'(irq), 0);
    rd(A_INT, d);  check("R10 only tx-done", d, 8'h04);
    check("R8 irq still low", int'(irq), 0);

    // R7 clear-on-read racing completion
    wr(A_CTRL, 8'h61);
    wr(A_TX, 8'h00);
    wr(A_CTRL, 8'h71);
    seen = 0;
    @(negedge clk);
    reg_addr = A_INT; reg_rd = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (reg_rdata[2]) seen++;
    end
    reg_rd = 1'b0;
    check("R7 completion seen exactly once", seen, 1);
    rd(A_INT, d);  check("R7 cleared after read", d, 8'h00);
    check("R8 irq low after clear", int'(irq), 0);
    rd(A_CTRL, d); check("R7 GO cleared", d, 8'h61);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule